// File: doc/BRIEF.md
# Per-thread fetch status controller

This block holds the fetch state of every hardware thread in a multithreaded instruction fetch stage. On each clock edge it reads stall and release pulses from the four stages below fetch, squash requests from commit and from decode, a per-thread flag saying the reorder buffer is still flushing, issue and completion events from the fetch datapath, and instruction-cache responses. From these it computes the next state of each thread. When a thread is squashed it also produces a redirected PC and the PC of the next instruction.

The stall pulses are kept as sticky per-stage flags, one set per thread. Squash sources are checked in a fixed order of priority. Every request issued to the cache advances a small per-thread tag. A response whose tag no longer matches, which arrives for a thread that is not waiting, or which arrives while the stage is switched out, is discarded and counted. A combinational activity output tells the pipeline clock gating whether fetch has useful work.

Thread states use this encoding: 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 WaitingCache, 5 CacheDone, 6 TrapPending, 7 QuiescePending. Stall input bit `s*NUM_THREADS + t` belongs to stage `s` (0 decode, 1 rename, 2 execute, 3 commit) and thread `t`. Per-thread buses are packed with thread 0 in the least significant slice.

Top module: `fetch_thread_status`

## Requirements
- R1: After a synchronous reset every thread is Running (0), every stall flag is clear, every request tag is 0, the drop counter is 0 and no redirect is flagged.
- R2: A stall pulse for any stage moves an active thread to Blocked (3) on the next edge. The thread stays Blocked until every stage that stalled it has sent its release pulse, and returns to Running on the edge of the last release. Stall and release must never be pulsed together for the same stage and thread.
- R3: While `ctx_switch` is high, every active thread that is not WaitingCache goes to Blocked. When it falls, those threads return to Running.
- R4: A commit squash takes priority over a decode squash, over stalls and over a cache response in the same cycle. The thread enters Squashing (2) and pulses `redirect_valid` for one cycle with `redirect_pc` set to the commit PC and `redirect_npc` to that PC plus INST_BYTES. This applies in any state, WaitingCache included.
- R5: While `rob_squashing` is high for a thread, it stays in Squashing.
- R6: A decode squash redirects a thread that is not Squashing, as in R4. A decode squash aimed at a thread already in Squashing has no effect: there is no redirect pulse and the redirect PC is unchanged.
- R7: A thread in WaitingCache does not move to Blocked because of a stall flag.
- R8: `req_issue` on a Running thread moves it to WaitingCache and advances its `req_tag` by one.
- R9: A response for a WaitingCache thread that carries the current tag, while `switched_out` is low, moves the thread to CacheDone (5). If the thread is stalled it moves to Blocked instead.
- R10: A response is dropped in three cases: its thread is not WaitingCache, its tag differs from the thread's current tag, or `switched_out` is high. A dropped response pulses `rsp_drop` on the next cycle and increments `drop_count`, and the thread's state is left unchanged.
- R11: `done_ack` returns a CacheDone thread to Running. `trap_evt` and `quiesce_evt` move a Running thread to TrapPending (6) or QuiescePending (7), and the thread holds that state until it is squashed.
- R12: A thread whose `thread_active` bit is low goes to Idle (1) and returns to Running once the bit is high again. `stage_active` is high exactly when some active thread is Running, Squashing or CacheDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NUM_THREADS | Threads currently scheduled on the core |
| ctx_switch | input | 1 | Global stall for a context switch |
| switched_out | input | 1 | Stage is switched out; all responses are discarded |
| stall_set | input | NUM_STAGES*NUM_THREADS | Stall pulses, bit s*NUM_THREADS+t |
| stall_clr | input | NUM_STAGES*NUM_THREADS | Release pulses, same layout |
| cmt_squash | input | NUM_THREADS | Squash request from commit |
| cmt_pc | input | NUM_THREADS*PC_W | Commit redirect PC per thread |
| rob_squashing | input | NUM_THREADS | Reorder buffer still flushing the thread |
| dec_squash | input | NUM_THREADS | Squash request from decode |
| dec_pc | input | NUM_THREADS*PC_W | Decode redirect PC per thread |
| req_issue | input | NUM_THREADS | Fetch datapath sent a cache request |
| trap_evt | input | NUM_THREADS | Fault detected; wait for a trap |
| quiesce_evt | input | NUM_THREADS | Quiesce instruction fetched |
| done_ack | input | NUM_THREADS | Fetch consumed the completed line |
| rsp_valid | input | 1 | Cache response strobe |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag carried by the response |
| thr_state | output | NUM_THREADS*3 | Encoded state per thread |
| req_tag | output | NUM_THREADS*TAG_W | Tag of each thread's latest request |
| redirect_valid | output | NUM_THREADS | One-cycle redirect pulse |
| redirect_pc | output | NUM_THREADS*PC_W | Last redirect PC |
| redirect_npc | output | NUM_THREADS*PC_W | Last redirect PC plus INST_BYTES |
| rsp_drop | output | 1 | A response was discarded last cycle |
| drop_count | output | CNT_W | Running count of discarded responses |
| stage_active | output | 1 | Fetch has useful work |

## Verification
A cache response and a squash can arrive for the same thread on the same edge. The bench forces this by issuing a request, then presenting the matching response and a commit squash together. It expects the squash to win: the thread is in Squashing, the redirect is pulsed, and the drop counter does not move because the response was valid. It then replays the same response and expects it to be counted as stale. A decode squash is also presented together with a commit squash and a new stall, to check the order in which these are resolved.

// File: rtl/fst_pkg.sv
package fst_pkg;

    typedef enum logic [2:0] {
        TS_RUN     = 3'd0,
        TS_IDLE    = 3'd1,
        TS_SQUASH  = 3'd2,
        TS_BLOCK   = 3'd3,
        TS_WAIT    = 3'd4,
        TS_DONE    = 3'd5,
        TS_TRAP    = 3'd6,
        TS_QUIESCE = 3'd7
    } thr_state_e;

    // Downstream stages feeding stall pulses: 0 decode, 1 rename, 2 execute, 3 commit
    localparam int STALL_SOURCES = 4;

    typedef struct packed {
        logic active;
        logic cmt_squash;
        logic rob_busy;
        logic dec_squash;
        logic issue;
        logic trap;
        logic quiesce;
        logic ack;
    } thr_evt_t;

    function automatic logic state_has_work(thr_state_e s);
        return (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_DONE);
    endfunction

endpackage

// File: rtl/fst_stall_flags.sv
module fst_stall_flags #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_STAGES  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] stall_set,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] stall_clr,
    output logic [NUM_THREADS-1:0]            flag_any_nxt
);
    localparam int NBITS = NUM_STAGES * NUM_THREADS;

    logic [NBITS-1:0] flag_q;
    logic [NBITS-1:0] flag_d;

    assign flag_d = (flag_q | stall_set) & ~stall_clr;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [NUM_STAGES-1:0] per_stage;
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stg
            assign per_stage[s] = flag_d[s*NUM_THREADS + t];
        end
        assign flag_any_nxt[t] = |per_stage;
    end

    AST_NO_SET_CLR_CLASH: assert property (@(posedge clk) disable iff (rst)
        (stall_set & stall_clr) == '0); // R2

endmodule

// File: rtl/fst_thread_fsm.sv
module fst_thread_fsm
    import fst_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int TAG_W      = 3,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  thr_evt_t          evt,
    input  logic [PC_W-1:0]   cmt_pc,
    input  logic [PC_W-1:0]   dec_pc,
    input  logic              stalled,
    input  logic              rsp_hit,
    output thr_state_e        st_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              redir_v,
    output logic [PC_W-1:0]   redir_pc,
    output logic [PC_W-1:0]   redir_npc
);
    thr_state_e        st_q, st_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic              rv_q, rv_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [PC_W-1:0]   npc_q;

    always_comb begin
        st_d  = st_q;
        tag_d = tag_q;
        rv_d  = 1'b0;
        pc_d  = pc_q;
        if (!evt.active) begin
            st_d = TS_IDLE;
        end else if (evt.cmt_squash) begin
            st_d = TS_SQUASH;
            rv_d = 1'b1;
            pc_d = cmt_pc;
        end else if (evt.rob_busy) begin
            st_d = TS_SQUASH;
        end else if (evt.dec_squash && st_q != TS_SQUASH) begin
            st_d = TS_SQUASH;
            rv_d = 1'b1;
            pc_d = dec_pc;
        end else if (stalled && st_q != TS_WAIT) begin
            st_d = TS_BLOCK;
        end else begin
            unique case (st_q)
                TS_IDLE, TS_BLOCK, TS_SQUASH: st_d = TS_RUN;
                TS_RUN: begin
                    if (evt.issue) begin
                        st_d  = TS_WAIT;
                        tag_d = tag_q + 1'b1;
                    end else if (evt.trap) begin
                        st_d = TS_TRAP;
                    end else if (evt.quiesce) begin
                        st_d = TS_QUIESCE;
                    end
                end
                TS_WAIT: begin
                    if (rsp_hit) st_d = stalled ? TS_BLOCK : TS_DONE;
                end
                TS_DONE: begin
                    if (evt.ack) st_d = TS_RUN;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TS_RUN;
            tag_q <= '0;
            rv_q  <= 1'b0;
            pc_q  <= '0;
            npc_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            rv_q  <= rv_d;
            pc_q  <= pc_d;
            if (rv_d) npc_q <= pc_d + PC_W'(INST_BYTES);
        end
    end

    assign st_o      = st_q;
    assign tag_o     = tag_q;
    assign redir_v   = rv_q;
    assign redir_pc  = pc_q;
    assign redir_npc = npc_q;

    AST_CMT_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt.active && evt.cmt_squash) |=> (st_q == TS_SQUASH && rv_q)); // R4

    AST_ROB_HOLDS_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (evt.active && evt.rob_busy) |=> st_q == TS_SQUASH); // R5

    AST_WAIT_IGNORES_STALL: assert property (@(posedge clk) disable iff (rst)
        (evt.active && !evt.cmt_squash && !evt.rob_busy && !evt.dec_squash &&
         st_q == TS_WAIT && !rsp_hit) |=> st_q == TS_WAIT); // R7

    AST_ISSUE_ADVANCES_TAG: assert property (@(posedge clk) disable iff (rst)
        (evt.active && !evt.cmt_squash && !evt.rob_busy && !evt.dec_squash &&
         !stalled && st_q == TS_RUN && evt.issue)
        |=> (st_q == TS_WAIT && tag_q == $past(tag_q) + 1'b1)); // R8

endmodule

// File: rtl/fst_rsp_filter.sv
module fst_rsp_filter
    import fst_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TAG_W       = 3,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    input  logic [TID_W-1:0]  rsp_tid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              switched_out,
    input  thr_state_e        st_i  [NUM_THREADS],
    input  logic [TAG_W-1:0]  tag_i [NUM_THREADS],
    output logic [NUM_THREADS-1:0] hit,
    output logic              rsp_drop,
    output logic [CNT_W-1:0]  drop_count
);
    logic drop_d;
    logic drop_q;
    logic [CNT_W-1:0] cnt_q;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_hit
        assign hit[t] = rsp_valid && !switched_out &&
                        (rsp_tid == TID_W'(t)) &&
                        (st_i[t] == TS_WAIT) &&
                        (tag_i[t] == rsp_tag);
    end

    assign drop_d = rsp_valid && (hit == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            drop_q <= drop_d;
            if (drop_d) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rsp_drop   = drop_q;
    assign drop_count = cnt_q;

    AST_HIT_ONE_THREAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R9

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (switched_out || st_i[rsp_tid] != TS_WAIT))
        |=> (rsp_drop && drop_count == $past(drop_count) + 1'b1)); // R10

endmodule

// File: rtl/fst_activity.sv
module fst_activity
    import fst_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  thr_state_e             st_i [NUM_THREADS],
    input  logic [NUM_THREADS-1:0] thread_active,
    output logic                   stage_active
);
    logic [NUM_THREADS-1:0] busy;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_busy
        assign busy[t] = thread_active[t] && state_has_work(st_i[t]);
    end

    assign stage_active = |busy;

endmodule

// File: rtl/fetch_thread_status.sv
module fetch_thread_status
    import fst_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_STAGES  = STALL_SOURCES,
    parameter int PC_W        = 32,
    parameter int TAG_W       = 3,
    parameter int INST_BYTES  = 4,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int ST_W       = $bits(thr_state_e)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_THREADS-1:0]            thread_active,
    input  logic                              ctx_switch,
    input  logic                              switched_out,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] stall_set,
    input  logic [NUM_STAGES*NUM_THREADS-1:0] stall_clr,
    input  logic [NUM_THREADS-1:0]            cmt_squash,
    input  logic [NUM_THREADS*PC_W-1:0]       cmt_pc,
    input  logic [NUM_THREADS-1:0]            rob_squashing,
    input  logic [NUM_THREADS-1:0]            dec_squash,
    input  logic [NUM_THREADS*PC_W-1:0]       dec_pc,
    input  logic [NUM_THREADS-1:0]            req_issue,
    input  logic [NUM_THREADS-1:0]            trap_evt,
    input  logic [NUM_THREADS-1:0]            quiesce_evt,
    input  logic [NUM_THREADS-1:0]            done_ack,
    input  logic                              rsp_valid,
    input  logic [TID_W-1:0]                  rsp_tid,
    input  logic [TAG_W-1:0]                  rsp_tag,
    output logic [NUM_THREADS*ST_W-1:0]       thr_state,
    output logic [NUM_THREADS*TAG_W-1:0]      req_tag,
    output logic [NUM_THREADS-1:0]            redirect_valid,
    output logic [NUM_THREADS*PC_W-1:0]       redirect_pc,
    output logic [NUM_THREADS*PC_W-1:0]       redirect_npc,
    output logic                              rsp_drop,
    output logic [CNT_W-1:0]                  drop_count,
    output logic                              stage_active
);
    logic [NUM_THREADS-1:0] flag_any;
    logic [NUM_THREADS-1:0] hit;
    thr_state_e             st   [NUM_THREADS];
    logic [TAG_W-1:0]       tags [NUM_THREADS];

    fst_stall_flags #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_STAGES  (NUM_STAGES)
    ) u_flags (
        .clk          (clk),
        .rst          (rst),
        .stall_set    (stall_set),
        .stall_clr    (stall_clr),
        .flag_any_nxt (flag_any)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        thr_evt_t evt;
        assign evt = '{
            active:     thread_active[t],
            cmt_squash: cmt_squash[t],
            rob_busy:   rob_squashing[t],
            dec_squash: dec_squash[t],
            issue:      req_issue[t],
            trap:       trap_evt[t],
            quiesce:    quiesce_evt[t],
            ack:        done_ack[t]
        };

        fst_thread_fsm #(
            .PC_W       (PC_W),
            .TAG_W      (TAG_W),
            .INST_BYTES (INST_BYTES)
        ) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .evt       (evt),
            .cmt_pc    (cmt_pc[t*PC_W +: PC_W]),
            .dec_pc    (dec_pc[t*PC_W +: PC_W]),
            .stalled   (flag_any[t] | ctx_switch),
            .rsp_hit   (hit[t]),
            .st_o      (st[t]),
            .tag_o     (tags[t]),
            .redir_v   (redirect_valid[t]),
            .redir_pc  (redirect_pc[t*PC_W +: PC_W]),
            .redir_npc (redirect_npc[t*PC_W +: PC_W])
        );

        assign thr_state[t*ST_W +: ST_W]  = st[t];
        assign req_tag[t*TAG_W +: TAG_W]  = tags[t];
    end

    fst_rsp_filter #(
        .NUM_THREADS (NUM_THREADS),
        .TAG_W       (TAG_W),
        .CNT_W       (CNT_W)
    ) u_filter (
        .clk          (clk),
        .rst          (rst),
        .rsp_valid    (rsp_valid),
        .rsp_tid      (rsp_tid),
        .rsp_tag      (rsp_tag),
        .switched_out (switched_out),
        .st_i         (st),
        .tag_i        (tags),
        .hit          (hit),
        .rsp_drop     (rsp_drop),
        .drop_count   (drop_count)
    );

    fst_activity #(
        .NUM_THREADS (NUM_THREADS)
    ) u_act (
        .st_i          (st),
        .thread_active (thread_active),
        .stage_active  (stage_active)
    );

endmodule

// File: tb/fetch_thread_status_tb_top.sv
`timescale 1ns/1ps
module fetch_thread_status_tb_top;
    localparam int NT  = 4;
    localparam int NS  = 4;
    localparam int PW  = 32;
    localparam int TW  = 3;
    localparam int CW  = 16;

    localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd1, S_SQ = 3'd2, S_BLK = 3'd3,
                           S_WAIT = 3'd4, S_DONE = 3'd5, S_TRAP = 3'd6, S_QUI = 3'd7;

    logic clk = 1'b0;
    logic rst;
    logic [NT-1:0]    thread_active;
    logic             ctx_switch, switched_out;
    logic [NS*NT-1:0] stall_set, stall_clr;
    logic [NT-1:0]    cmt_squash, rob_squashing, dec_squash;
    logic [NT*PW-1:0] cmt_pc, dec_pc;
    logic [NT-1:0]    req_issue, trap_evt, quiesce_evt, done_ack;
    logic             rsp_valid;
    logic [1:0]       rsp_tid;
    logic [TW-1:0]    rsp_tag;
    logic [NT*3-1:0]  thr_state;
    logic [NT*TW-1:0] req_tag;
    logic [NT-1:0]    redirect_valid;
    logic [NT*PW-1:0] redirect_pc, redirect_npc;
    logic             rsp_drop;
    logic [CW-1:0]    drop_count;
    logic             stage_active;

    int n_chk = 0;
    int n_err = 0;
    int exp_drop = 0;
    logic [TW-1:0] exp_tag [NT];

    always #4 clk = ~clk;

    fetch_thread_status dut_i (
        .clk(clk), .rst(rst), .thread_active(thread_active), .ctx_switch(ctx_switch),
        .switched_out(switched_out), .stall_set(stall_set), .stall_clr(stall_clr),
        .cmt_squash(cmt_squash), .cmt_pc(cmt_pc), .rob_squashing(rob_squashing),
        .dec_squash(dec_squash), .dec_pc(dec_pc), .req_issue(req_issue),
        .trap_evt(trap_evt), .quiesce_evt(quiesce_evt), .done_ack(done_ack),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_tag(rsp_tag),
        .thr_state(thr_state), .req_tag(req_tag), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .redirect_npc(redirect_npc), .rsp_drop(rsp_drop),
        .drop_count(drop_count), .stage_active(stage_active)
    );

    function automatic logic [2:0] st(int t);
        return thr_state[t*3 +: 3];
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clr_pulses();
        stall_set = '0; stall_clr = '0; cmt_squash = '0; rob_squashing = '0;
        dec_squash = '0; req_issue = '0; trap_evt = '0; quiesce_evt = '0;
        done_ack = '0; rsp_valid = 1'b0; rsp_tid = '0; rsp_tag = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clr_pulses();
    endtask

    task automatic t_reset();
        for (int t = 0; t < NT; t++) begin
            chk($sformatf("R1 state t%0d", t), 64'(st(t)), 64'(S_RUN));
            chk($sformatf("R1 tag t%0d", t), 64'(req_tag[t*TW +: TW]), 64'd0);
        end
        chk("R1 drop_count", 64'(drop_count), 64'd0);
        chk("R1 redirect_valid", 64'(redirect_valid), 64'd0);
        chk("R12 stage_active after reset", 64'(stage_active), 64'd1);
    endtask

    task automatic t_sticky_stall();
        stall_set[1*NT + 0] = 1'b1;
        tick();
        chk("R2 blocked by rename", 64'(st(0)), 64'(S_BLK));
        chk("R2 other thread running", 64'(st(1)), 64'(S_RUN));
        stall_set[2*NT + 0] = 1'b1;
        tick();
        stall_clr[1*NT + 0] = 1'b1;
        tick();
        chk("R2 still blocked by execute", 64'(st(0)), 64'(S_BLK));
        tick();
        chk("R2 sticky with no pulse", 64'(st(0)), 64'(S_BLK));
        stall_clr[2*NT + 0] = 1'b1;
        tick();
        chk("R2 released", 64'(st(0)), 64'(S_RUN));
    endtask

    task automatic t_ctx_switch();
        ctx_switch = 1'b1;
        tick();
        for (int t = 0; t < NT; t++)
            chk($sformatf("R3 ctx blocks t%0d", t), 64'(st(t)), 64'(S_BLK));
        chk("R12 inactive when all blocked", 64'(stage_active), 64'd0);
        ctx_switch = 1'b0;
        tick();
        chk("R3 ctx release", 64'(st(2)), 64'(S_RUN));
    endtask

    task automatic t_issue_response();
        req_issue[2] = 1'b1;
        tick();
        exp_tag[2] = exp_tag[2] + 1'b1;
        chk("R8 issue enters wait", 64'(st(2)), 64'(S_WAIT));
        chk("R8 tag advanced", 64'(req_tag[2*TW +: TW]), 64'(exp_tag[2]));
        rsp_valid = 1'b1; rsp_tid = 2'd2; rsp_tag = exp_tag[2] - 1'b1;
        tick();
        exp_drop++;
        chk("R10 wrong tag dropped", 64'(rsp_drop), 64'd1);
        chk("R10 wrong tag counted", 64'(drop_count), 64'(exp_drop));
        chk("R10 wrong tag leaves wait", 64'(st(2)), 64'(S_WAIT));
        stall_set[0*NT + 2] = 1'b1;
        tick();
        chk("R7 wait not blocked", 64'(st(2)), 64'(S_WAIT));
        chk("R10 drop pulse single", 64'(rsp_drop), 64'd0);
        rsp_valid = 1'b1; rsp_tid = 2'd2; rsp_tag = exp_tag[2];
        tick();
        chk("R9 stalled response blocks", 64'(st(2)), 64'(S_BLK));
        chk("R9 valid not counted", 64'(drop_count), 64'(exp_drop));
        stall_clr[0*NT + 2] = 1'b1;
        tick();
        chk("R2 unblock after response", 64'(st(2)), 64'(S_RUN));
        req_issue[2] = 1'b1;
        tick();
        exp_tag[2] = exp_tag[2] + 1'b1;
        rsp_valid = 1'b1; rsp_tid = 2'd2; rsp_tag = exp_tag[2];
        tick();
        chk("R9 response completes", 64'(st(2)), 64'(S_DONE));
        tick();
        chk("R11 done holds without ack", 64'(st(2)), 64'(S_DONE));
        done_ack[2] = 1'b1;
        tick();
        chk("R11 ack returns to run", 64'(st(2)), 64'(S_RUN));
    endtask

    task automatic t_drop_cases();
        rsp_valid = 1'b1; rsp_tid = 2'd3; rsp_tag = exp_tag[3];
        tick();
        exp_drop++;
        chk("R10 not waiting dropped", 64'(drop_count), 64'(exp_drop));
        chk("R10 not waiting state kept", 64'(st(3)), 64'(S_RUN));
        req_issue[3] = 1'b1;
        tick();
        exp_tag[3] = exp_tag[3] + 1'b1;
        switched_out = 1'b1;
        rsp_valid = 1'b1; rsp_tid = 2'd3; rsp_tag = exp_tag[3];
        tick();
        switched_out = 1'b0;
        exp_drop++;
        chk("R10 switched out dropped", 64'(drop_count), 64'(exp_drop));
        chk("R10 switched out still waiting", 64'(st(3)), 64'(S_WAIT));
        rsp_valid = 1'b1; rsp_tid = 2'd3; rsp_tag = exp_tag[3];
        tick();
        chk("R9 accepted after switch in", 64'(st(3)), 64'(S_DONE));
        done_ack[3] = 1'b1;
        tick();
    endtask

    task automatic t_squash_priority();
        cmt_squash[0] = 1'b1; cmt_pc[0*PW +: PW] = 32'h0000_1000;
        dec_squash[0] = 1'b1; dec_pc[0*PW +: PW] = 32'h0000_2000;
        stall_set[0*NT + 0] = 1'b1;
        tick();
        chk("R4 commit wins state", 64'(st(0)), 64'(S_SQ));
        chk("R4 redirect pulse", 64'(redirect_valid[0]), 64'd1);
        chk("R4 redirect pc", 64'(redirect_pc[0*PW +: PW]), 64'h1000);
        chk("R4 redirect npc", 64'(redirect_npc[0*PW +: PW]), 64'h1004);
        stall_clr[0*NT + 0] = 1'b1;
        tick();
        chk("R4 pulse ends", 64'(redirect_valid[0]), 64'd0);
        chk("R4 squash to run", 64'(st(0)), 64'(S_RUN));
    endtask

    task automatic t_rob_and_decode();
        cmt_squash[1] = 1'b1; cmt_pc[1*PW +: PW] = 32'h0000_0300;
        tick();
        rob_squashing[1] = 1'b1;
        tick();
        chk("R5 rob holds squash", 64'(st(1)), 64'(S_SQ));
        rob_squashing[1] = 1'b1;
        tick();
        chk("R5 rob holds squash again", 64'(st(1)), 64'(S_SQ));
        dec_squash[1] = 1'b1; dec_pc[1*PW +: PW] = 32'h0000_0500;
        tick();
        chk("R6 decode ignored no pulse", 64'(redirect_valid[1]), 64'd0);
        chk("R6 decode ignored pc kept", 64'(redirect_pc[1*PW +: PW]), 64'h300);
        chk("R6 squash ends", 64'(st(1)), 64'(S_RUN));
        dec_squash[1] = 1'b1; dec_pc[1*PW +: PW] = 32'h0000_0600;
        tick();
        chk("R6 decode redirect state", 64'(st(1)), 64'(S_SQ));
        chk("R6 decode redirect pulse", 64'(redirect_valid[1]), 64'd1);
        chk("R6 decode redirect npc", 64'(redirect_npc[1*PW +: PW]), 64'h604);
        tick();
    endtask

    task automatic t_squash_vs_response();
        req_issue[2] = 1'b1;
        tick();
        exp_tag[2] = exp_tag[2] + 1'b1;
        rsp_valid = 1'b1; rsp_tid = 2'd2; rsp_tag = exp_tag[2];
        cmt_squash[2] = 1'b1; cmt_pc[2*PW +: PW] = 32'h0000_0800;
        tick();
        chk("R4 squash beats response", 64'(st(2)), 64'(S_SQ));
        chk("R4 squash beats response pc", 64'(redirect_pc[2*PW +: PW]), 64'h800);
        chk("R10 matching response not dropped", 64'(drop_count), 64'(exp_drop));
        tick();
        rsp_valid = 1'b1; rsp_tid = 2'd2; rsp_tag = exp_tag[2];
        tick();
        exp_drop++;
        chk("R10 late response dropped", 64'(drop_count), 64'(exp_drop));
        chk("R10 late response state kept", 64'(st(2)), 64'(S_RUN));
    endtask

    task automatic t_trap_quiesce();
        trap_evt[3] = 1'b1;
        tick();
        chk("R11 trap entered", 64'(st(3)), 64'(S_TRAP));
        tick();
        chk("R11 trap held", 64'(st(3)), 64'(S_TRAP));
        cmt_squash[3] = 1'b1; cmt_pc[3*PW +: PW] = 32'h0000_0A00;
        tick();
        tick();
        chk("R11 trap left by squash", 64'(st(3)), 64'(S_RUN));
        quiesce_evt[3] = 1'b1;
        tick();
        chk("R11 quiesce entered", 64'(st(3)), 64'(S_QUI));
        dec_squash[3] = 1'b1; dec_pc[3*PW +: PW] = 32'h0000_0B00;
        tick();
        chk("R11 quiesce left by decode squash", 64'(st(3)), 64'(S_SQ));
        tick();
    endtask

    task automatic t_idle();
        thread_active = 4'b1101;
        tick();
        chk("R12 inactive thread idle", 64'(st(1)), 64'(S_IDLE));
        chk("R12 stage active with others", 64'(stage_active), 64'd1);
        thread_active = 4'b0000;
        #1;
        chk("R12 no active thread", 64'(stage_active), 64'd0);
        thread_active = 4'b1111;
        tick();
        chk("R12 idle back to run", 64'(st(1)), 64'(S_RUN));
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) exp_tag[t] = '0;
        clr_pulses();
        thread_active = '1; ctx_switch = 1'b0; switched_out = 1'b0;
        cmt_pc = '0; dec_pc = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_sticky_stall();
        t_ctx_switch();
        t_issue_response();
        t_drop_cases();
        t_squash_priority();
        t_rob_and_decode();
        t_squash_vs_response();
        t_trap_quiesce();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule